// File: doc/BRIEF.md
# Byte-Addressed Seconds Counter

This block keeps a 32-bit count of elapsed seconds. It advances once for each pulse on a one-per-second tick input while it is running. Software reaches it through a byte-wide register port, which has an address, a write strobe, write data and combinational read data. Through that port software loads the count one byte at a time, starts and stops it with a run bit, reads it back one byte at a time, and identifies the peripheral through a fixed type code. The full live count also leaves the block on a parallel bus, so that a neighbouring alarm comparator can watch it.

A byte load lands directly in the running count, and the counter keeps running while software loads it. If the low byte is written early, later ticks can carry into bytes that software has not written yet. The safe load sequence is therefore: zero the low byte, write the three upper bytes, then write the low byte last. Byte reads are not atomic either. When the low byte reads smaller on a second read than on the first, a carry took place between the two reads.

Top module: `sec_tally_top`

## Requirements
- R1: After reset the count is 0 and the run bit is clear, so tick pulses leave the count at 0.
- R2: A read at offset 0x05 returns the type code 0x01. A write there changes neither that value nor any other state.
- R3: Bit 7 of the run-control register at offset 0x46 is the run bit. A write loads it from write-data bit 7. A read returns it in bit 7, with bits 6:0 always 0.
- R4: While the run bit is set, each tick pulse adds one to the count. While it is clear, the count holds.
- R5: A tick while running at 0xFFFFFFFF gives 0.
- R6: A write to offset 0x40+k (k = 0..3) replaces bits 8k+7:8k of the live count at that clock edge and leaves the other bytes unchanged. In that cycle the write takes priority over a coincident tick, which is dropped.
- R7: Once the low byte holds 0xFF, a tick while running carries into byte 1, so a low byte written before the upper bytes can disturb them.
- R8: A read at offset 0x48+k (k = 0..3) returns bits 8k+7:8k of the live count (little-endian). The live count is always present on the parallel count output.
- R9: Reads at every other offset return 0x00, and this includes the write-only load offsets 0x40-0x43. Writes to unmapped offsets change neither the count nor the run bit.
- R10: While the write strobe is low, no address or data value changes any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 8 | Register offset |
| regWe | input | 1 | Write strobe, one cycle per write |
| regWdata | input | 8 | Write data byte |
| regRdata | output | 8 | Read data for regAddr, combinational |
| tickPulse | input | 1 | One-cycle pulse per second |
| countOut | output | 32 | Live seconds count |

## Verification
The bench loads the count in the safe order and in unsafe orders. It parks the low byte at 0xFF so that a tick must carry into byte 1, and it runs the count across the 32-bit wrap. A design that swaps byte lanes, or that lets a write also take a coincident tick, gives wrong byte reads or a count that is off by one. The bench also drives a tick in the same cycle as a byte write, writes the control register with only its low bits set, and writes to the type offset and to unmapped offsets. A decoder that is too loose in any of these cases would change the run state or the count, or would return nonzero data at holes in the map.

// File: rtl/sec_tally_pkg.sv
package sec_tally_pkg;
  localparam int BYTE_W    = 8;
  localparam int NUM_LANES = 4;
  localparam int LANE_IDX_W = $clog2(NUM_LANES);
  localparam int COUNT_W   = BYTE_W * NUM_LANES;

  typedef enum logic [1:0] {
    RD_ZERO,
    RD_TYPE,
    RD_CTRL,
    RD_COUNT
  } rdSrc_e;

  // Strobes from the decoder to the datapath
  typedef struct packed {
    logic [NUM_LANES-1:0]  byteWr;
    logic                  ctrlWr;
    rdSrc_e                rdSrc;
    logic [LANE_IDX_W-1:0] rdLane;
  } regStrobe_t;
endpackage

// File: rtl/sec_tally_ctrl.sv
module sec_tally_ctrl
  import sec_tally_pkg::*;
#(
  parameter int              ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] LOAD_BASE = 8'h40,
  parameter logic [ADDR_W-1:0] RUN_ADDR  = 8'h46,
  parameter logic [ADDR_W-1:0] READ_BASE = 8'h48,
  parameter logic [ADDR_W-1:0] TYPE_ADDR = 8'h05
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  output regStrobe_t        strobe
);

  always_comb begin
    strobe        = '0;
    strobe.rdSrc  = RD_ZERO;
    for (int lane = 0; lane < NUM_LANES; lane++) begin
      if (regAddr == ADDR_W'(LOAD_BASE + ADDR_W'(lane))) begin
        strobe.byteWr[lane] = regWe;
      end
      if (regAddr == ADDR_W'(READ_BASE + ADDR_W'(lane))) begin
        strobe.rdSrc  = RD_COUNT;
        strobe.rdLane = LANE_IDX_W'(lane);
      end
    end
    if (regAddr == RUN_ADDR) begin
      strobe.rdSrc  = RD_CTRL;
      strobe.ctrlWr = regWe;
    end
    if (regAddr == TYPE_ADDR) begin
      strobe.rdSrc = RD_TYPE;
    end
  end

  // R9
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.byteWr, strobe.ctrlWr}));

  // R10
  no_write_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !regWe |-> (strobe.byteWr == '0 && !strobe.ctrlWr));

endmodule

// File: rtl/sec_tally_dp.sv
module sec_tally_dp
  import sec_tally_pkg::*;
#(
  parameter logic [BYTE_W-1:0] TYPE_VALUE = 8'h01,
  parameter int                RUN_BIT    = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  regStrobe_t         strobe,
  input  logic [BYTE_W-1:0]  wrData,
  input  logic               tick,
  output logic [BYTE_W-1:0]  rdData,
  output logic [COUNT_W-1:0] countOut
);

  logic [COUNT_W-1:0] count;
  logic [COUNT_W-1:0] loaded;
  logic               runEn;
  logic               anyLoad;

  assign anyLoad  = |strobe.byteWr;
  assign countOut = count;

  for (genvar lane = 0; lane < NUM_LANES; lane++) begin : g_lane
    assign loaded[lane*BYTE_W +: BYTE_W] =
      strobe.byteWr[lane] ? wrData : count[lane*BYTE_W +: BYTE_W];

    // R6
    lane_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
      (anyLoad && !strobe.byteWr[lane]) |=>
        count[lane*BYTE_W +: BYTE_W] == $past(count[lane*BYTE_W +: BYTE_W]));

    // R6
    lane_load_chk: assert property (@(posedge clk) disable iff (!rstN)
      strobe.byteWr[lane] |=> count[lane*BYTE_W +: BYTE_W] == $past(wrData));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
      runEn <= 1'b0;
    end else begin
      if (strobe.ctrlWr) runEn <= wrData[RUN_BIT];
      if (anyLoad) begin
        count <= loaded;
      end else if (runEn && tick) begin
        count <= count + COUNT_W'(1);
      end
    end
  end

  always_comb begin
    rdData = '0;
    unique case (strobe.rdSrc)
      RD_TYPE:  rdData = TYPE_VALUE;
      RD_CTRL:  rdData[RUN_BIT] = runEn;
      RD_COUNT: rdData = count[strobe.rdLane*BYTE_W +: BYTE_W];
      default:  rdData = '0;
    endcase
  end

  // R4
  hold_when_stopped_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!runEn && !anyLoad) |=> $stable(count));

  // R4
  step_on_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && tick && !anyLoad) |=> count == $past(count) + COUNT_W'(1));

  // R5
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && tick && !anyLoad && (&count)) |=> count == '0);

  // R3
  run_bit_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ctrlWr |=> runEn == $past(wrData[RUN_BIT]));

endmodule

// File: rtl/sec_tally_top.sv
module sec_tally_top
  import sec_tally_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regWe,
  input  logic [BYTE_W-1:0]  regWdata,
  output logic [BYTE_W-1:0]  regRdata,
  input  logic               tickPulse,
  output logic [COUNT_W-1:0] countOut
);

  regStrobe_t strobe;

  sec_tally_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .regAddr (regAddr),
    .regWe   (regWe),
    .strobe  (strobe)
  );

  sec_tally_dp dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrData   (regWdata),
    .tick     (tickPulse),
    .rdData   (regRdata),
    .countOut (countOut)
  );

endmodule

// File: tb/sec_tally_top_tb_top.sv
module sec_tally_top_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  regAddr = 8'h00;
  logic        regWe = 1'b0;
  logic [7:0]  regWdata = 8'h00;
  logic [7:0]  regRdata;
  logic        tickPulse = 1'b0;
  logic [31:0] countOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] expCount = 32'h0;
  bit          expEn    = 1'b0;

  typedef struct {
    logic [7:0] addr;
    logic [7:0] exp;
    string      req;
  } rdItem_t;

  rdItem_t scoreQ[$];

  always #2 clk = ~clk;

  sec_tally_top dut_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .tickPulse(tickPulse),
    .countOut(countOut)
  );

  // Monitor: pops expected read items and compares away from the edge
  always @(negedge clk) begin
    if (scoreQ.size() > 0) begin
      rdItem_t it;
      it = scoreQ.pop_front();
      checks++;
      if (regRdata !== it.exp) begin
        fails++;
        $display("FAIL %s read @%02h: actual %02h expected %02h",
                 it.req, it.addr, regRdata, it.exp);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input bit withTick);
    bit loadHit;
    @(posedge clk); #1;
    regAddr = a; regWdata = d; regWe = 1'b1; tickPulse = withTick;
    @(posedge clk); #1;
    regWe = 1'b0; tickPulse = 1'b0;
    loadHit = (a >= 8'h40 && a <= 8'h43);
    if (loadHit) expCount[(a - 8'h40)*8 +: 8] = d;
    else if (withTick && expEn) expCount = expCount + 32'd1;
    if (a == 8'h46) expEn = d[7];
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      tickPulse = 1'b1;
      @(posedge clk); #1;
      tickPulse = 1'b0;
      if (expEn) expCount = expCount + 32'd1;
    end
  endtask

  task automatic rdChk(input logic [7:0] a, input logic [7:0] exp, input string req);
    @(posedge clk); #1;
    regAddr = a;
    scoreQ.push_back('{a, exp, req});
  endtask

  task automatic cntChk(input string req);
    @(negedge clk);
    checks++;
    if (countOut !== expCount) begin
      fails++;
      $display("FAIL %s count: actual %08h expected %08h", req, countOut, expCount);
    end
  endtask

  task automatic rdCountBytes(input string req);
    for (int k = 0; k < 4; k++) rdChk(8'(8'h48 + k), expCount[k*8 +: 8], req);
  endtask

  task automatic loadSafe(input logic [31:0] v);
    wr(8'h40, 8'h00, 1'b0);
    wr(8'h41, v[15:8], 1'b0);
    wr(8'h42, v[23:16], 1'b0);
    wr(8'h43, v[31:24], 1'b0);
    wr(8'h40, v[7:0], 1'b0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state and stopped counter
    cntChk("R1");
    rdChk(8'h46, 8'h00, "R1");
    tick(3);
    cntChk("R1");

    // R2 type code, write ignored
    rdChk(8'h05, 8'h01, "R2");
    wr(8'h05, 8'hAA, 1'b0);
    rdChk(8'h05, 8'h01, "R2");
    rdChk(8'h46, 8'h00, "R2");
    cntChk("R2");

    // R6 / R8 safe load and little-endian readback
    loadSafe(32'h12345678);
    cntChk("R6");
    rdCountBytes("R8");

    // R3 run bit, low bits never read back
    wr(8'h46, 8'hFF, 1'b0);
    rdChk(8'h46, 8'h80, "R3");
    // R4 counting
    tick(3);
    cntChk("R4");
    rdChk(8'h48, 8'h7B, "R4");

    // R3 write with bit 7 clear stops; R4 hold
    wr(8'h46, 8'h7F, 1'b0);
    rdChk(8'h46, 8'h00, "R3");
    tick(2);
    cntChk("R4");

    // R5 wrap
    wr(8'h46, 8'h80, 1'b0);
    loadSafe(32'hFFFFFFFF);
    tick(1);
    cntChk("R5");
    rdCountBytes("R5");

    // R7 carry from low byte into byte 1
    wr(8'h40, 8'hFF, 1'b0);
    tick(1);
    cntChk("R7");
    rdChk(8'h49, 8'h01, "R7");
    rdChk(8'h48, 8'h00, "R7");

    // R6 write wins over coincident tick
    wr(8'h42, 8'hAB, 1'b1);
    cntChk("R6");
    rdCountBytes("R6");

    // R9 unmapped reads and writes
    rdChk(8'h40, 8'h00, "R9");
    rdChk(8'h43, 8'h00, "R9");
    rdChk(8'h47, 8'h00, "R9");
    rdChk(8'h4C, 8'h00, "R9");
    rdChk(8'h00, 8'h00, "R9");
    wr(8'h47, 8'h00, 1'b0);
    wr(8'h4C, 8'h55, 1'b0);
    wr(8'h3F, 8'h00, 1'b0);
    rdChk(8'h46, 8'h80, "R9");
    cntChk("R9");

    // R10 strobe low changes nothing
    @(posedge clk); #1;
    regAddr = 8'h41; regWdata = 8'h99; regWe = 1'b0;
    @(posedge clk); #1;
    regAddr = 8'h46; regWdata = 8'h00;
    @(posedge clk); #1;
    cntChk("R10");
    rdChk(8'h46, 8'h80, "R10");

    repeat (3) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule